// File: doc/BRIEF.md
# Triangular-Hadamard Gaussian Sample Generator

This block supplies a wide vector of roughly normally distributed random numbers, one full vector per enabled cycle, for datapaths that need cheap noise rather than precise statistics. Each lane first forms a triangular variate by adding two centred 16-bit slices taken from two independent 32-bit xorshift generators. The sixteen triangular values then pass through a pipelined 16-point Hadamard network of add/subtract butterflies. Every output is a signed mix of all sixteen inputs, so the central limit effect pushes each lane towards a bell shape.

The generator bank and the transform are separate units joined by a registered stream of lane values. A small control unit turns the seed-load and enable inputs into strobes. It also runs a valid shift register alongside the data. Loading a seed re-initialises all 32 generators from one 32-bit value. Each generator gets a distinct derived seed, and none can be zero.

Top module: `tri_hadamard_rng`

## Requirements
- R1: While and directly after reset, outValid is 0 and every outData bit is 0. The generators start from seeds derived from the parameter DEF_SEED using the rule in R3.
- R2: Each generator is a 32-bit xorshift: x ^= x<<13, then x ^= x>>17, then x ^= x<<5. It advances once per cycle in which enable is 1 and seedLoad is 0. Lane l uses generator 2l as its first operand and generator 2l+1 as its second.
- R3: A cycle with seedLoad=1 sets generator g to seedVal XOR (g * 0x9E3779B9 mod 2^32). If that value is zero, it is replaced by 0x2545F491. No generator state is ever zero.
- R4: seedLoad takes priority over enable. A load cycle neither advances the generators nor produces a valid output vector.
- R5: The triangular value of a lane is (a[31:16] - 32768) + (b[31:16] - 32768) as a signed number. It is formed from the generator states held before that cycle's step.
- R6: Output lane k is y[k] = sum over i of (-1)^popcount(i AND k) * t[i], arithmetically shifted right by 2. It is a 19-bit two's-complement value at outData[19k+18:19k].
- R7: An enabled, non-load cycle sampled at rising edge n makes outValid 1 after edge n+4, carrying that cycle's vector. outValid is 0 in every other cycle.
- R8: When enable is 0, the generators hold, and the next enabled cycle continues the same sequence. While outValid is 0, outData keeps its last value.
- R9: Consecutive enabled cycles give one new vector per cycle, in generator order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load all generators from seedVal this cycle |
| seedVal | input | 32 | Base seed value |
| enable | input | 1 | Request one sample vector this cycle |
| outValid | output | 1 | outData holds a new vector this cycle |
| outData | output | 304 | Sixteen 19-bit signed samples, lane k at bits [19k+18:19k] |

## Verification
The vector requested by an enable sampled at edge n is due after edge n+4. The generator step and the triangular register take the first edge, and the four butterfly stages take the remaining four. The bench keeps an eight-slot ring of expected vectors and valid flags. It files each request in the slot five ticks ahead and reads that slot back at the falling edge after the due edge. Cycles with no slot entry are checked for a low valid and an unchanged outData. Load cycles, including one with enable also high, file an entry with valid low.

// File: rtl/tri_rng_pkg.sv
package tri_rng_pkg;

  localparam int UW = 32;
  localparam logic [UW-1:0] SEED_MIX  = 32'h9E37_79B9;
  localparam logic [UW-1:0] SEED_SUBST = 32'h2545_F491;

  typedef struct packed {
    logic load;
    logic step;
  } rngCtl_t;

  function automatic logic [UW-1:0] xsStep(input logic [UW-1:0] x);
    logic [UW-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [UW-1:0] seedFor(input logic [UW-1:0] base, input logic [UW-1:0] idx);
    logic [UW-1:0] v;
    v = base ^ (SEED_MIX * idx);
    return (v == '0) ? SEED_SUBST : v;
  endfunction

endpackage

// File: rtl/tri_rng_ctrl.sv
module tri_rng_ctrl
  import tri_rng_pkg::*;
#(
  parameter int STG = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         seedLoad,
  input  logic         enable,
  output rngCtl_t      ctl,
  output logic [STG:0] adv,
  output logic         outValid
);

  logic [STG:0] vPipe;

  assign ctl.load = seedLoad;
  assign ctl.step = enable & ~seedLoad;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STG-1:0], ctl.step};
  end

  assign adv      = {vPipe[STG-1:0], ctl.step};
  assign outValid = vPipe[STG];

  // R4
  load_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> !vPipe[0]);

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(enable, STG + 1) && !$past(seedLoad, STG + 1)));

endmodule

// File: rtl/tri_rng_bank.sv
module tri_rng_bank
  import tri_rng_pkg::*;
#(
  parameter int            LANES    = 16,
  parameter int            TW       = 16,
  parameter logic [UW-1:0] DEF_SEED = 32'h1234_ABCD,
  localparam int           NG       = 2 * LANES,
  localparam int           TRW      = TW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rngCtl_t              ctl,
  input  logic [UW-1:0]        seedVal,
  output logic [LANES*TRW-1:0] triOut
);

  logic [UW-1:0] genState [NG];

  for (genvar g = 0; g < NG; g++) begin : genG
    logic [UW-1:0] st;
    always_ff @(posedge clk) begin
      if (!rstN)         st <= seedFor(DEF_SEED, UW'(g));
      else if (ctl.load) st <= seedFor(seedVal, UW'(g));
      else if (ctl.step) st <= xsStep(st);
    end
    assign genState[g] = st;

    // R3
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      st != '0);
  end

  for (genvar l = 0; l < LANES; l++) begin : laneG
    logic [UW-1:0]        a, b;
    logic signed [TRW-1:0] ca, cb, tr;
    assign a  = genState[2*l];
    assign b  = genState[2*l+1];
    assign ca = {~a[UW-1], ~a[UW-1], a[UW-2:UW-TW]};
    assign cb = {~b[UW-1], ~b[UW-1], b[UW-2:UW-TW]};
    always_ff @(posedge clk) begin
      if (!rstN)         tr <= '0;
      else if (ctl.step) tr <= ca + cb;
    end
    assign triOut[l*TRW +: TRW] = tr;
  end

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> genState[0] == seedFor($past(seedVal), '0));

endmodule

// File: rtl/tri_rng_hadamard.sv
module tri_rng_hadamard #(
  parameter int  LANES = 16,
  parameter int  IW    = 17,
  parameter int  SHR   = 2,
  localparam int STG   = $clog2(LANES),
  localparam int AW    = IW + STG,
  localparam int OW    = AW - SHR
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STG:1]        adv,
  input  logic [LANES*IW-1:0] inWord,
  output logic [LANES*OW-1:0] outWord
);

  logic signed [AW-1:0] tap [STG+1][LANES];

  for (genvar i = 0; i < LANES; i++) begin : inG
    assign tap[0][i] = {{(AW-IW){inWord[i*IW+IW-1]}}, inWord[i*IW +: IW]};
  end

  for (genvar s = 0; s < STG; s++) begin : stageG
    logic signed [AW-1:0] bf [LANES];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < LANES; i++) bf[i] <= '0;
      end else if (adv[s+1]) begin
        for (int i = 0; i < LANES; i++) begin
          if (((i >> s) & 1) == 0) bf[i] <= tap[s][i] + tap[s][i ^ (1 << s)];
          else                     bf[i] <= tap[s][i ^ (1 << s)] - tap[s][i];
        end
      end
    end
    for (genvar i = 0; i < LANES; i++) begin : tapG
      assign tap[s+1][i] = bf[i];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : outG
    logic signed [AW-1:0] scaled;
    assign scaled = tap[STG][k] >>> SHR;
    assign outWord[k*OW +: OW] = scaled[OW-1:0];
  end

endmodule

// File: rtl/tri_hadamard_rng.sv
module tri_hadamard_rng
  import tri_rng_pkg::*;
#(
  parameter int            LANES    = 16,
  parameter int            TW       = 16,
  parameter logic [31:0]   DEF_SEED = 32'h1234_ABCD,
  localparam int           STG      = $clog2(LANES),
  localparam int           TRW      = TW + 1,
  localparam int           OW       = TRW + STG - 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                seedLoad,
  input  logic [31:0]         seedVal,
  input  logic                enable,
  output logic                outValid,
  output logic [LANES*OW-1:0] outData
);

  rngCtl_t              ctl;
  logic [STG:0]         adv;
  logic [LANES*TRW-1:0] triBus;

  tri_rng_ctrl #(.STG(STG)) ctrl_i (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .enable(enable),
    .ctl(ctl), .adv(adv), .outValid(outValid)
  );

  tri_rng_bank #(.LANES(LANES), .TW(TW), .DEF_SEED(DEF_SEED)) bank_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seedVal(seedVal), .triOut(triBus)
  );

  tri_rng_hadamard #(.LANES(LANES), .IW(TRW), .SHR(2)) had_i (
    .clk(clk), .rstN(rstN), .adv(adv[STG:1]), .inWord(triBus), .outWord(outData)
  );

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

endmodule

// File: tb/tri_hadamard_rng_tb_top.sv
module tri_hadamard_rng_tb_top;

  localparam int L  = 16;
  localparam int OW = 19;
  localparam int NG = 32;
  localparam logic [31:0] DSEED = 32'h1234_ABCD;

  logic clk = 0;
  logic rstN = 0;
  logic seedLoad = 0;
  logic [31:0] seedVal = '0;
  logic enable = 0;
  logic outValid;
  logic [L*OW-1:0] outData;

  always #2 clk = ~clk;

  tri_hadamard_rng #(.LANES(L), .TW(16), .DEF_SEED(DSEED)) dut_i (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedVal(seedVal),
    .enable(enable), .outValid(outValid), .outData(outData)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0]     mState [NG];
  bit              expV [8];
  logic [L*OW-1:0] expD [8];
  string           vTag [8];
  string           dTag [8];
  logic [L*OW-1:0] lastD = '0;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] seedOf(input logic [31:0] s, input int g);
    logic [31:0] v;
    v = s ^ (32'h9E37_79B9 * 32'(g));
    return (v == 0) ? 32'h2545_F491 : v;
  endfunction

  function automatic logic [L*OW-1:0] refVec(input logic [31:0] st [NG]);
    int t [L];
    logic [L*OW-1:0] r;
    for (int i = 0; i < L; i++)
      t[i] = (int'(st[2*i][31:16]) - 32768) + (int'(st[2*i+1][31:16]) - 32768);
    for (int k = 0; k < L; k++) begin
      int y = 0;
      for (int i = 0; i < L; i++)
        if ($countones(i & k) % 2 == 0) y += t[i];
        else                            y -= t[i];
      y = y >>> 2;
      r[k*OW +: OW] = y[OW-1:0];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [L*OW-1:0] act, input logic [L*OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit ld, input bit en, input logic [31:0] sv, input string dt);
    int slot;
    slot = (cyc + 5) % 8;
    seedLoad = ld; enable = en; seedVal = sv;
    expV[slot] = en && !ld;
    vTag[slot] = ld ? "R4" : "R7";
    dTag[slot] = dt;
    if (ld) begin
      for (int g = 0; g < NG; g++) mState[g] = seedOf(sv, g);
    end else if (en) begin
      expD[slot] = refVec(mState);
      for (int g = 0; g < NG; g++) mState[g] = xs(mState[g]);
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    slot = cyc % 8;
    chk(outValid == expV[slot], vTag[slot], L*OW'(outValid), L*OW'(expV[slot]));
    if (expV[slot]) begin
      chk(outData == expD[slot], dTag[slot], outData, expD[slot]);
      lastD = expD[slot];
    end else begin
      chk(outData == lastD, "R8", outData, lastD);
    end
    expV[slot] = 0;
    vTag[slot] = "R7";
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED_0001);
    for (int i = 0; i < 8; i++) begin expV[i] = 0; vTag[i] = "R7"; dTag[i] = "R6"; end
    for (int g = 0; g < NG; g++) mState[g] = seedOf(DSEED, g);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while held
    chk(outValid == 0 && outData == '0, "R1", outData, '0);
    rstN = 1;
    @(posedge clk); @(negedge clk);
    chk(outValid == 0 && outData == '0, "R1", outData, '0);

    // R1/R9: back-to-back from default seeds
    for (int i = 0; i < 8; i++) tick(0, 1, '0, "R9");
    // R8: idle gap, then the sequence continues
    for (int i = 0; i < 7; i++) tick(0, 0, '0, "R8");
    tick(0, 1, '0, "R8");
    for (int i = 0; i < 6; i++) tick(0, 0, '0, "R8");
    // R3: zero seed uses the substitute for generator 0
    tick(1, 0, 32'h0, "R3");
    for (int i = 0; i < 4; i++) tick(0, 1, '0, "R3");
    // R4: load wins over enable
    tick(1, 1, 32'hDEAD_BEEF, "R4");
    tick(0, 1, '0, "R4");
    tick(0, 0, '0, "R4");
    tick(0, 1, '0, "R2/R5/R6");
    for (int i = 0; i < 6; i++) tick(0, 0, '0, "R8");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      bit ld, en;
      ld = ($urandom % 23) == 0;
      en = ($urandom % 4) != 0;
      tick(ld, en, $urandom, "R2/R5/R6");
    end
    for (int i = 0; i < 8; i++) tick(0, 0, '0, "R8");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule